// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 64-bit virtual address into a page frame address, a set of granted permissions and a fault code. A request carries the address, the kind of access (probe, read, write or execute), a two-bit privilege mode index (0 is the kernel) and a flag that skips translation. The walker also takes the base address of the top-level table. Non-canonical addresses are rejected, and a kernel superpage window is mapped directly. Every other address is resolved by reading up to three 8-byte table entries, one at a time, through a simple request/response memory port.

The walker takes one request at a time. A one-cycle done strobe marks the point where the physical address, permission and fault outputs become valid. Those outputs then hold their values until the next translation completes. Pages are 8 KiB (page shift 13), each table level is indexed by 10 bits, and the implemented virtual width is 43 bits.

Top module: `ptw_walker`

## Requirements
- R1: After reset, done_o and mem_req_o are low.
- R2: With bypass_i set, pa_o equals va_i, perm_o is 3'b111 and fault_o is 0 (none). done_o rises one cycle after acceptance and no memory request is made.
- R3: If bits 63:43 of a non-bypass address are not all equal, the result is fault_o=1 (access violation), with pa_o=0 and perm_o=0, one cycle after acceptance.
- R4: A canonical address with bit 63 set and bits 42:41 equal to 2'b10 is a superpage and makes no memory request. In mode 0 the result has pa_o[39:0]=va_i[39:0], pa_o[43]=va_i[40], all other pa_o bits 0, perm_o=3'b111 and no fault. In modes 1-3 the result is an access violation with pa_o=0 and perm_o=0.
- R5: Otherwise, entries are read from base+index*8 using the indices va[42:33], va[32:23] and va[22:13], in that order. The first base is ptbr_i. Each following base, and the final pa_o, is entry bits 63:32 shifted left by 13.
- R6: Only one memory request is outstanding at a time. mem_req_o stays high with a stable mem_addr_o until a cycle with mem_rsp_valid_i. done_o is a one-cycle pulse in the cycle after the response that ends the walk.
- R7: An entry whose valid bit (bit 0) is clear gives fault_o=2 (not valid) with perm_o=0 and ends the walk. At levels 1 and 2 pa_o is 0; at level 3 pa_o is the frame address.
- R8: A valid level-1 or level-2 entry with bit 8 (kernel read enable) clear gives an access violation, with pa_o=0 and perm_o=0, and ends the walk.
- R9: In the leaf entry, bit 8+mode grants read and execute and bit 12+mode grants write (perm_o bit0 read, bit1 write, bit2 execute). A nonzero request that is not granted gives an access violation, and perm_o shows the granted set.
- R10: Granted permissions are cleared by leaf bits 1 (read), 2 (write) and 3 (execute). A request still unmet after this gives fault_o 5 for execute, 4 for write or 3 for read, checked in that priority.
- R11: A probe (acc_i=0; read=1, write=2, execute=3) never gives a fault code of 3, 4 or 5 and never gives a leaf access violation.
- R12: req_valid_i is ignored while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Start a translation (taken when idle) |
| va_i | input | 64 | Virtual address |
| acc_i | input | 2 | Access: 0 probe, 1 read, 2 write, 3 execute |
| mode_i | input | 2 | Privilege mode index, 0 = kernel |
| bypass_i | input | 1 | Physical bypass, no translation |
| ptbr_i | input | 64 | Top-level table base address |
| mem_req_o | output | 1 | Table entry read request |
| mem_addr_o | output | 64 | Table entry address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Table entry data |
| done_o | output | 1 | Result valid strobe |
| pa_o | output | 64 | Physical frame address |
| perm_o | output | 3 | Granted permissions {exec, write, read} |
| fault_o | output | 3 | 0 none, 1 access violation, 2 not valid, 3/4/5 fault on read/write/execute |

## Verification
The bypass, non-canonical and superpage results arrive in the cycle after acceptance. The bench checks done_o at the first falling edge after the accepting edge and expects a wait count of zero. A walk whose memory answers L cycles after each request rises takes L+1 cycles per level read. The bench therefore expects done_o after exactly (L+1) times the number of levels read, and it compares the logged entry addresses and the request count with that number. All outputs are sampled on falling edges, and inputs and memory responses are driven there as well.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PTE_W   = 64;
  localparam int LEVELS  = 3;
  localparam int PTE_V   = 0;
  localparam int PTE_FOR = 1;
  localparam int PTE_FOE = 3;
  localparam int PTE_KRE = 8;
  localparam int PTE_KWE = 12;

  typedef enum logic [1:0] {ACC_PROBE, ACC_READ, ACC_WRITE, ACC_EXEC} acc_e;
  typedef enum logic [2:0] {F_NONE, F_ACV, F_TNV, F_FOR, F_FOW, F_FOE} fault_e;
  typedef enum logic [2:0] {C_WALK, C_BYPASS, C_NONCANON, C_SUPER, C_SUPER_DENY} class_e;
  typedef enum logic [2:0] {ST_IDLE, ST_L1, ST_L2, ST_L3, ST_DONE} state_e;

  // permission vector: bit0 read, bit1 write, bit2 execute
  function automatic logic [2:0] acc_need(acc_e a);
    unique case (a)
      ACC_READ:  return 3'b001;
      ACC_WRITE: return 3'b010;
      ACC_EXEC:  return 3'b100;
      default:   return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/ptw_classify.sv
module ptw_classify
  import ptw_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int VIRT_BITS = 43
) (
  input  logic [ADDR_W-1:0] va_i,
  input  logic [1:0]        mode_i,
  input  logic              bypass_i,
  output class_e            cls_o,
  output logic [ADDR_W-1:0] super_pa_o
);
  localparam int REMAP_SRC = VIRT_BITS - 3;
  localparam int REMAP_DST = VIRT_BITS;

  logic [ADDR_W-VIRT_BITS-1:0] upper;
  logic canon, super_hit;

  assign upper     = va_i[ADDR_W-1:VIRT_BITS];
  assign canon     = (&upper) | ~(|upper);
  assign super_hit = va_i[ADDR_W-1] && (va_i[VIRT_BITS-1 -: 2] == 2'b10);

  always_comb begin
    super_pa_o = '0;
    super_pa_o[REMAP_SRC-1:0] = va_i[REMAP_SRC-1:0];
    super_pa_o[REMAP_DST]     = va_i[REMAP_SRC];
  end

  always_comb begin
    if (bypass_i)       cls_o = C_BYPASS;
    else if (!canon)    cls_o = C_NONCANON;
    else if (super_hit) cls_o = (mode_i == 2'd0) ? C_SUPER : C_SUPER_DENY;
    else                cls_o = C_WALK;
  end
endmodule

// File: rtl/ptw_level_check.sv
module ptw_level_check
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte_i,
  output fault_e           fault_o
);
  logic unused_bits;
  assign unused_bits = ^{pte_i[PTE_W-1:PTE_KRE+1], pte_i[PTE_KRE-1:PTE_V+1]};

  always_comb begin
    if (!pte_i[PTE_V])        fault_o = F_TNV;
    else if (!pte_i[PTE_KRE]) fault_o = F_ACV;
    else                      fault_o = F_NONE;
  end
endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
  import ptw_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 13
) (
  input  logic [PTE_W-1:0]  pte_i,
  input  acc_e              acc_i,
  input  logic [1:0]        mode_i,
  output logic [ADDR_W-1:0] pa_o,
  output logic [2:0]        perm_o,
  output fault_e            fault_o
);
  logic [2:0] need, granted, masked;
  logic rd_en, wr_en;
  logic unused_bits;

  assign unused_bits = ^{pte_i[31:PTE_KWE+4], pte_i[PTE_KRE-1:PTE_FOE+1]};
  assign need    = acc_need(acc_i);
  assign rd_en   = pte_i[PTE_KRE + int'(mode_i)];
  assign wr_en   = pte_i[PTE_KWE + int'(mode_i)];
  assign granted = {rd_en, wr_en, rd_en};
  // entry bits 3:1 are fault-on {exec, write, read}
  assign masked  = granted & ~pte_i[PTE_FOE:PTE_FOR];
  assign pa_o    = ADDR_W'(pte_i[PTE_W-1:32]) << PAGE_SHIFT;

  always_comb begin
    perm_o  = '0;
    fault_o = F_NONE;
    if (!pte_i[PTE_V]) begin
      fault_o = F_TNV;
    end else if ((need != 3'b000) && ((granted & need) == 3'b000)) begin
      perm_o  = granted;
      fault_o = F_ACV;
    end else begin
      perm_o = masked;
      if ((need != 3'b000) && ((masked & need) == 3'b000)) begin
        if (need[2])      fault_o = F_FOE;
        else if (need[1]) fault_o = F_FOW;
        else              fault_o = F_FOR;
      end
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 13,
  parameter int IDX_W      = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] va_i,
  input  logic [1:0]        acc_i,
  input  logic [1:0]        mode_i,
  input  logic              bypass_i,
  input  logic [ADDR_W-1:0] ptbr_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [PTE_W-1:0]  mem_rsp_data_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] pa_o,
  output logic [2:0]        perm_o,
  output logic [2:0]        fault_o
);
  localparam int VPN_W     = LEVELS * IDX_W;
  localparam int VIRT_BITS = PAGE_SHIFT + VPN_W;

  state_e            state_q;
  logic [VPN_W-1:0]  vpn_q;
  acc_e              acc_q;
  logic [1:0]        mode_q;
  logic [ADDR_W-1:0] base_q, pa_q;
  logic [2:0]        perm_q;
  fault_e            fault_q;

  class_e            cls;
  logic [ADDR_W-1:0] super_pa, leaf_pa, next_base;
  fault_e            lvl_fault, leaf_fault;
  logic [2:0]        leaf_perm;
  logic [IDX_W-1:0]  lvl_idx [LEVELS];
  logic [IDX_W-1:0]  cur_idx;

  ptw_classify #(.ADDR_W(ADDR_W), .VIRT_BITS(VIRT_BITS)) u_classify (
    .va_i(va_i), .mode_i(mode_i), .bypass_i(bypass_i),
    .cls_o(cls), .super_pa_o(super_pa)
  );

  ptw_level_check u_level_check (.pte_i(mem_rsp_data_i), .fault_o(lvl_fault));

  ptw_leaf_eval #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_leaf_eval (
    .pte_i(mem_rsp_data_i), .acc_i(acc_q), .mode_i(mode_q),
    .pa_o(leaf_pa), .perm_o(leaf_perm), .fault_o(leaf_fault)
  );

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign lvl_idx[g] = vpn_q[IDX_W*(LEVELS-1-g) +: IDX_W];
  end

  always_comb begin
    unique case (state_q)
      ST_L2:   cur_idx = lvl_idx[1];
      ST_L3:   cur_idx = lvl_idx[2];
      default: cur_idx = lvl_idx[0];
    endcase
  end

  assign next_base  = ADDR_W'(mem_rsp_data_i[PTE_W-1:32]) << PAGE_SHIFT;
  assign mem_req_o  = (state_q == ST_L1) || (state_q == ST_L2) || (state_q == ST_L3);
  assign mem_addr_o = base_q + (ADDR_W'(cur_idx) << 3);
  assign done_o     = (state_q == ST_DONE);
  assign pa_o       = pa_q;
  assign perm_o     = perm_q;
  assign fault_o    = fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vpn_q   <= '0;
      acc_q   <= ACC_PROBE;
      mode_q  <= '0;
      base_q  <= '0;
      pa_q    <= '0;
      perm_q  <= '0;
      fault_q <= F_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            vpn_q  <= va_i[VIRT_BITS-1:PAGE_SHIFT];
            acc_q  <= acc_e'(acc_i);
            mode_q <= mode_i;
            base_q <= ptbr_i;
            unique case (cls)
              C_BYPASS: begin
                pa_q <= va_i; perm_q <= 3'b111; fault_q <= F_NONE; state_q <= ST_DONE;
              end
              C_SUPER: begin
                pa_q <= super_pa; perm_q <= 3'b111; fault_q <= F_NONE; state_q <= ST_DONE;
              end
              C_NONCANON, C_SUPER_DENY: begin
                pa_q <= '0; perm_q <= '0; fault_q <= F_ACV; state_q <= ST_DONE;
              end
              default: state_q <= ST_L1;
            endcase
          end
        end
        ST_L1, ST_L2: begin
          if (mem_rsp_valid_i) begin
            if (lvl_fault != F_NONE) begin
              pa_q <= '0; perm_q <= '0; fault_q <= lvl_fault; state_q <= ST_DONE;
            end else begin
              base_q  <= next_base;
              state_q <= (state_q == ST_L1) ? ST_L2 : ST_L3;
            end
          end
        end
        ST_L3: begin
          if (mem_rsp_valid_i) begin
            pa_q <= leaf_pa; perm_q <= leaf_perm; fault_q <= leaf_fault; state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!done_o && !mem_req_o));

  a_r2_bypass_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_valid_i && bypass_i) |=>
      (done_o && pa_o == $past(va_i) && perm_o == 3'b111 && fault_o == F_NONE));

  a_r6_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_tnv_no_perm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == F_TNV) |-> (perm_o == 3'b000));

  a_r10_fow_clears_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == F_FOW) |-> !perm_o[1]);

  a_r11_probe_no_fo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && acc_q == ACC_PROBE) |->
      (fault_o != F_FOR && fault_o != F_FOW && fault_o != F_FOE));

  a_r12_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_valid_i) |=> mem_req_o);
endmodule

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] va = '0;
  logic [1:0]  acc = '0;
  logic [1:0]  mode = '0;
  logic        byp = 1'b0;
  logic [63:0] ptbr = 64'h0010_0000;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        rsp_valid = 1'b0;
  logic [63:0] rsp_data = '0;
  logic        done;
  logic [63:0] pa;
  logic [2:0]  perm;
  logic [2:0]  fault;

  always #5 clk = ~clk;

  ptw_walker u_ptw_walker (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .va_i(va),
    .acc_i(acc), .mode_i(mode), .bypass_i(byp), .ptbr_i(ptbr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
    .done_o(done), .pa_o(pa), .perm_o(perm), .fault_o(fault)
  );

  localparam logic [31:0] FV = 32'h1, FFOR = 32'h2, FFOW = 32'h4, FFOE = 32'h8;
  localparam logic [31:0] FKRE = 32'h100, FKWE = 32'h1000;
  localparam logic [31:0] FURE = 32'h800, FUWE = 32'h8000;
  localparam logic [31:0] PFN1 = 32'h200, PFN2 = 32'h300, PFN3 = 32'h1234;

  int total = 0, failed = 0;
  int lat = 1;
  int wcnt = 0;
  int nreq = 0;
  logic [63:0] req_log [8];
  logic [63:0] pmem [logic [63:0]];
  logic [63:0] r_pa;
  logic [2:0]  r_perm, r_fault;
  int r_cyc;

  function automatic logic [63:0] rd(logic [63:0] a);
    return pmem.exists(a) ? pmem[a] : 64'h0;
  endfunction

  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt >= lat) begin
        rsp_valid <= 1'b1; rsp_data <= rd(mem_addr); wcnt <= 0;
      end else begin
        rsp_valid <= 1'b0; wcnt <= wcnt + 1;
      end
    end else begin
      rsp_valid <= 1'b0; wcnt <= 0;
    end
  end

  always @(posedge clk) begin
    if (mem_req && rsp_valid) begin
      if (nreq < 8) req_log[nreq] = mem_addr;
      nreq = nreq + 1;
    end
  end

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_va(int i1, int i2, int i3);
    return (64'(i1) << 33) | (64'(i2) << 23) | (64'(i3) << 13) | 64'h155;
  endfunction

  task automatic build(logic [31:0] f1, logic [31:0] f2, logic [31:0] f3);
    pmem.delete();
    pmem[ptbr + 64'd24] = {PFN1, f1};
    pmem[(64'(PFN1) << 13) + 64'd40] = {PFN2, f2};
    pmem[(64'(PFN2) << 13) + 64'd56] = {PFN3, f3};
  endtask

  task automatic run(logic [63:0] v, logic [1:0] a, logic [1:0] m, logic b);
    @(negedge clk);
    nreq = 0;
    va = v; acc = a; mode = m; byp = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    r_cyc = 0;
    while (!done && r_cyc < 1000) begin
      @(negedge clk);
      r_cyc++;
    end
    r_pa = pa; r_perm = perm; r_fault = fault;
  endtask

  task automatic t_reset;
    chk("R1", "done after reset", 64'(done), 64'd0);
    chk("R1", "mem_req after reset", 64'(mem_req), 64'd0);
  endtask

  task automatic t_bypass;
    run(64'hdead_beef_1234_5678, 2'd2, 2'd3, 1'b1);
    chk("R2", "bypass pa", r_pa, 64'hdead_beef_1234_5678);
    chk("R2", "bypass perm", 64'(r_perm), 64'd7);
    chk("R2", "bypass fault", 64'(r_fault), 64'd0);
    chk("R2", "bypass latency", 64'(r_cyc), 64'd0);
    chk("R2", "bypass no reads", 64'(nreq), 64'd0);
  endtask

  task automatic t_noncanon;
    run(64'h0000_0800_0000_0000, 2'd1, 2'd0, 1'b0);
    chk("R3", "bit43 fault", 64'(r_fault), 64'd1);
    chk("R3", "bit43 pa", r_pa, 64'd0);
    chk("R3", "bit43 latency", 64'(r_cyc), 64'd0);
    run(64'h8000_0000_0000_0000, 2'd0, 2'd0, 1'b0);
    chk("R3", "sign-only fault", 64'(r_fault), 64'd1);
    chk("R3", "sign-only perm", 64'(r_perm), 64'd0);
    chk("R3", "no reads", 64'(nreq), 64'd0);
  endtask

  task automatic t_super;
    logic [63:0] v, e;
    v = 64'hFFFF_FD12_3456_789A;
    e = (v & ((64'd1 << 40) - 1)) | (((v >> 40) & 64'd1) << 43);
    run(v, 2'd1, 2'd0, 1'b0);
    chk("R4", "kseg pa bit40->43", r_pa, e);
    chk("R4", "kseg perm", 64'(r_perm), 64'd7);
    chk("R4", "kseg fault", 64'(r_fault), 64'd0);
    chk("R4", "kseg no reads", 64'(nreq), 64'd0);
    v = 64'hFFFF_FC00_0000_0ABC;
    run(v, 2'd1, 2'd0, 1'b0);
    chk("R4", "kseg pa bit40 clear", r_pa, 64'h0ABC);
    run(v, 2'd1, 2'd3, 1'b0);
    chk("R4", "user kseg fault", 64'(r_fault), 64'd1);
    chk("R4", "user kseg pa", r_pa, 64'd0);
  endtask

  task automatic t_walk_ok;
    lat = 2;
    build(FV | FKRE, FV | FKRE, FV | FKRE | FKWE);
    run(mk_va(3, 5, 7), 2'd1, 2'd0, 1'b0);
    chk("R5", "read count", 64'(nreq), 64'd3);
    chk("R5", "L1 addr", req_log[0], ptbr + 64'd24);
    chk("R5", "L2 addr", req_log[1], (64'(PFN1) << 13) + 64'd40);
    chk("R5", "L3 addr", req_log[2], (64'(PFN2) << 13) + 64'd56);
    chk("R5", "walk pa", r_pa, 64'(PFN3) << 13);
    chk("R5", "walk perm", 64'(r_perm), 64'd7);
    chk("R5", "walk fault", 64'(r_fault), 64'd0);
    chk("R6", "walk latency lat2", 64'(r_cyc), 64'(3 * (lat + 1)));
    lat = 0;
    run(mk_va(3, 5, 7), 2'd1, 2'd0, 1'b0);
    chk("R6", "walk latency lat0", 64'(r_cyc), 64'd3);
    lat = 1;
  endtask

  task automatic t_level_faults;
    build(FV, FV | FKRE, FV | FKRE);
    run(mk_va(3, 5, 7), 2'd1, 2'd0, 1'b0);
    chk("R8", "L1 no KRE fault", 64'(r_fault), 64'd1);
    chk("R8", "L1 stops after one read", 64'(nreq), 64'd1);
    chk("R6", "L1 fault latency", 64'(r_cyc), 64'(lat + 1));
    build(FV | FKRE, FKRE, FV | FKRE);
    run(mk_va(3, 5, 7), 2'd1, 2'd0, 1'b0);
    chk("R7", "L2 invalid fault", 64'(r_fault), 64'd2);
    chk("R7", "L2 invalid reads", 64'(nreq), 64'd2);
    chk("R7", "L2 invalid pa", r_pa, 64'd0);
    build(FV | FKRE, FV | FKRE, FKRE | FKWE);
    run(mk_va(3, 5, 7), 2'd1, 2'd0, 1'b0);
    chk("R7", "L3 invalid fault", 64'(r_fault), 64'd2);
    chk("R7", "L3 invalid pa", r_pa, 64'(PFN3) << 13);
    chk("R7", "L3 invalid perm", 64'(r_perm), 64'd0);
  endtask

  task automatic t_mode;
    build(FV | FKRE, FV | FKRE, FV | FURE);
    run(mk_va(3, 5, 7), 2'd1, 2'd3, 1'b0);
    chk("R9", "user read fault", 64'(r_fault), 64'd0);
    chk("R9", "user read perm", 64'(r_perm), 64'd5);
    run(mk_va(3, 5, 7), 2'd2, 2'd3, 1'b0);
    chk("R9", "user write fault", 64'(r_fault), 64'd1);
    chk("R9", "user write perm", 64'(r_perm), 64'd5);
    run(mk_va(3, 5, 7), 2'd1, 2'd0, 1'b0);
    chk("R9", "kernel read of user page", 64'(r_fault), 64'd1);
    chk("R9", "kernel perm of user page", 64'(r_perm), 64'd0);
    build(FV | FKRE, FV | FKRE, FV | FUWE);
    run(mk_va(3, 5, 7), 2'd2, 2'd3, 1'b0);
    chk("R9", "user write-only perm", 64'(r_perm), 64'd2);
  endtask

  task automatic t_fault_on;
    build(FV | FKRE, FV | FKRE, FV | FKRE | FKWE | FFOW);
    run(mk_va(3, 5, 7), 2'd2, 2'd0, 1'b0);
    chk("R10", "FOW fault", 64'(r_fault), 64'd4);
    chk("R10", "FOW perm", 64'(r_perm), 64'd5);
    build(FV | FKRE, FV | FKRE, FV | FKRE | FKWE | FFOE);
    run(mk_va(3, 5, 7), 2'd3, 2'd0, 1'b0);
    chk("R10", "FOE fault", 64'(r_fault), 64'd5);
    chk("R10", "FOE perm", 64'(r_perm), 64'd3);
    build(FV | FKRE, FV | FKRE, FV | FKRE | FKWE | FFOR);
    run(mk_va(3, 5, 7), 2'd1, 2'd0, 1'b0);
    chk("R10", "FOR fault", 64'(r_fault), 64'd3);
    chk("R10", "FOR perm", 64'(r_perm), 64'd6);
    run(mk_va(3, 5, 7), 2'd2, 2'd0, 1'b0);
    chk("R10", "FOR with write ok", 64'(r_fault), 64'd0);
  endtask

  task automatic t_probe;
    build(FV | FKRE, FV | FKRE, FV);
    run(mk_va(3, 5, 7), 2'd0, 2'd0, 1'b0);
    chk("R11", "probe no enables fault", 64'(r_fault), 64'd0);
    chk("R11", "probe no enables perm", 64'(r_perm), 64'd0);
    build(FV | FKRE, FV | FKRE, FV | FKRE | FFOR | FFOE);
    run(mk_va(3, 5, 7), 2'd0, 2'd0, 1'b0);
    chk("R11", "probe fault-on fault", 64'(r_fault), 64'd0);
    chk("R11", "probe fault-on perm", 64'(r_perm), 64'd0);
  endtask

  task automatic t_busy;
    int seen;
    lat = 3;
    build(FV | FKRE, FV | FKRE, FV | FKRE | FKWE);
    @(negedge clk);
    nreq = 0;
    va = mk_va(3, 5, 7); acc = 2'd1; mode = 2'd0; byp = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    va = 64'h1111; byp = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; byp = 1'b0;
    r_cyc = 0;
    while (!done && r_cyc < 1000) begin
      @(negedge clk);
      r_cyc++;
    end
    chk("R12", "busy result pa", pa, 64'(PFN3) << 13);
    chk("R12", "busy result fault", 64'(fault), 64'd0);
    seen = 0;
    repeat (4) begin
      @(negedge clk);
      if (done) seen++;
    end
    chk("R12", "no second result", 64'(seen), 64'd0);
    lat = 1;
  endtask

  initial begin
    #2_000_000;
    total++; failed++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_noncanon();
    t_super();
    t_walk_ok();
    t_level_faults();
    t_mode();
    t_fault_on();
    t_probe();
    t_busy();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule